// File: doc/BRIEF.md
# Packet Length Counter with End-of-Packet Tagging

This block sits between a host and a transmit byte FIFO that feeds a serial framer. The host programs the length of the next packet through a small register port. The host's FIFO write strobes and data bytes pass through the block unchanged. The block adds one extra tag bit that marks the final byte of the packet, so the framer knows where to close the frame without any per-byte bookkeeping by the host.

The live count steps down by one on the clock edge that ends each FIFO write. The byte written while the count is one is tagged as end of packet. With the repeat mode bit clear, the count then rests at zero and tags nothing further until the host reprograms it. With the repeat mode bit set, the count reloads from a shadow copy of the last programmed length, so fixed-length packets follow one another with no further host action. The live count can be read back at any time.

Top module: `pkt_len_tagger`

## Requirements
- R1: After synchronous active-high reset the live count reads 0, the shadow length is 0 and repeat mode is off, so no byte is tagged.
- R2: A host write with `host_sel`=0 loads `host_wdata` into both the live count and the shadow length; `cnt_rd` shows the new value from the next cycle.
- R3: A FIFO write (`in_valid`=1) while the count is above 1 lowers the count by exactly one at the clock edge that ends the write; without a write the count holds.
- R4: A FIFO write made while the count is 1 leaves with `out_eop`=1; writes made at any other count leave with `out_eop`=0.
- R5: With repeat mode off, the count is 0 after the tagged byte, and later writes are untagged and leave it at 0.
- R6: With repeat mode on, the count reloads to the shadow length at the edge ending the tagged byte, so packets of that length repeat; repeat mode is set or cleared by a host write with `host_sel`=1 taking the mode from `host_wdata` bit 0, and it governs the next reload.
- R7: A programmed length of 0 disables tagging entirely, in either mode.
- R8: `out_valid` and `out_data` equal `in_valid` and `in_data` in the same cycle.
- R9: When a length write and a FIFO write fall in the same cycle, the byte's tag follows the count before the edge and the count takes the written length.
- R10: Reset clears repeat mode, so a packet after reset ends at zero even if repeat mode was set before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects the length register, 1 selects the mode register |
| host_wdata | input | CNT_W | Host write data; bit 0 is the repeat mode bit for a mode write |
| in_valid | input | 1 | FIFO write strobe from the host |
| in_data | input | DATA_W | FIFO write byte from the host |
| out_valid | output | 1 | FIFO write strobe toward the FIFO |
| out_data | output | DATA_W | FIFO write byte toward the FIFO |
| out_eop | output | 1 | End-of-packet tag for the byte being written |
| cnt_rd | output | CNT_W | Live count readback |

## Verification
The counter is driven with a three-byte packet in single-shot mode and then with more writes after the tag, which separates a correct rest at zero from a counter that wraps or keeps tagging. Two-byte and one-byte packets in repeat mode show that the reload takes the shadow length rather than the last live value, and that a length of one tags every byte. A length of zero in repeat mode shows that zero disables tagging instead of reloading endlessly. Idle cycles show that the count moves only on writes. Length writes that fall in the same cycle as FIFO writes, at count 5 and at count 1, show which value the tag and the new count follow. A reset issued while repeat mode is on shows that the mode bit is cleared.

// File: rtl/pkt_len_pkg.sv
package pkt_len_pkg;

    typedef enum logic {
        SEL_LENGTH = 1'b0,
        SEL_MODE   = 1'b1
    } host_sel_e;

    typedef struct packed {
        logic load;
        logic adv;
        logic repeat_on;
    } cnt_ctrl_t;

endpackage

// File: rtl/plc_cfg_regs.sv
module plc_cfg_regs
    import pkt_len_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [CNT_W-1:0] host_wdata,
    output logic             len_load,
    output logic [CNT_W-1:0] shadow_len,
    output logic             repeat_on
);

    always_comb begin
        len_load = host_we && (host_sel_e'(host_sel) == SEL_LENGTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_len <= '0;
            repeat_on  <= 1'b0;
        end else if (host_we) begin
            if (host_sel_e'(host_sel) == SEL_LENGTH) begin
                shadow_len <= host_wdata;
            end else begin
                repeat_on <= host_wdata[0];
            end
        end
    end

    // R10
    mode_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (repeat_on == 1'b0 && shadow_len == '0));

endmodule

// File: rtl/plc_down_counter.sv
module plc_down_counter
    import pkt_len_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] shadow_len,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tag
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_d;
    logic             at_last;

    always_comb begin
        at_last = (cnt_q == CNT_ONE);
        tag     = ctrl.adv && at_last;
        cnt_d   = cnt_q;
        if (ctrl.load) begin
            cnt_d = load_val;
        end else if (ctrl.adv) begin
            if (at_last) begin
                cnt_d = ctrl.repeat_on ? shadow_len : CNT_ZERO;
            end else if (cnt_q != CNT_ZERO) begin
                cnt_d = cnt_q - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2
    load_takes_value_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.load |=> (cnt_q == $past(load_val)));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.adv && !ctrl.load && cnt_q > CNT_ONE) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.adv && !ctrl.load) |=> $stable(cnt_q));

    // R5
    rest_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_ZERO && !ctrl.load) |=> (cnt_q == CNT_ZERO));

    // R6
    reload_after_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (tag && !ctrl.load) |=>
            (cnt_q == ($past(ctrl.repeat_on) ? $past(shadow_len) : CNT_ZERO)));

    // R7
    zero_no_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_ZERO) |-> !tag);

endmodule

// File: rtl/pkt_len_tagger.sv
module pkt_len_tagger
    import pkt_len_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [CNT_W-1:0]  host_wdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eop,
    output logic [CNT_W-1:0]  cnt_rd
);

    logic             len_load;
    logic [CNT_W-1:0] shadow_len;
    logic             repeat_on;
    cnt_ctrl_t        ctrl;
    logic             tag;

    plc_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .len_load   (len_load),
        .shadow_len (shadow_len),
        .repeat_on  (repeat_on)
    );

    always_comb begin
        ctrl.load      = len_load;
        ctrl.adv       = in_valid;
        ctrl.repeat_on = repeat_on;
    end

    plc_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .load_val   (host_wdata),
        .shadow_len (shadow_len),
        .cnt_q      (cnt_rd),
        .tag        (tag)
    );

    always_comb begin
        out_valid = in_valid;
        out_data  = in_data;
        out_eop   = tag;
    end

    // R4
    eop_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> out_valid);

endmodule

// File: tb/tb_pkt_len_tagger.sv
module tb_pkt_len_tagger;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;
    localparam int NVEC   = 22;

    // op: 0 idle, 1 fifo write, 2 length write, 3 mode write
    // entry: {op[1:0], data[7:0], exp_eop, exp_cnt_after[7:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd2, 8'h03, 1'b0, 8'd3},  // R2 length 3
        {2'd1, 8'hAA, 1'b0, 8'd2},  // R3
        {2'd1, 8'hBB, 1'b0, 8'd1},  // R3
        {2'd1, 8'hCC, 1'b1, 8'd0},  // R4 tag at one
        {2'd1, 8'hDD, 1'b0, 8'd0},  // R5 rest at zero
        {2'd0, 8'h00, 1'b0, 8'd0},  // R5
        {2'd3, 8'h01, 1'b0, 8'd0},  // R6 repeat on
        {2'd2, 8'h02, 1'b0, 8'd2},  // R2 length 2
        {2'd1, 8'h11, 1'b0, 8'd1},  // R3
        {2'd1, 8'h22, 1'b1, 8'd2},  // R6 reload
        {2'd1, 8'h33, 1'b0, 8'd1},  // R6
        {2'd1, 8'h44, 1'b1, 8'd2},  // R6
        {2'd0, 8'h00, 1'b0, 8'd2},  // R3 idle holds
        {2'd2, 8'h00, 1'b0, 8'd0},  // R7 length 0
        {2'd1, 8'h55, 1'b0, 8'd0},  // R7
        {2'd1, 8'h66, 1'b0, 8'd0},  // R7
        {2'd2, 8'h01, 1'b0, 8'd1},  // R2 length 1
        {2'd1, 8'h77, 1'b1, 8'd1},  // R6 every byte tagged
        {2'd1, 8'h88, 1'b1, 8'd1},  // R6
        {2'd3, 8'h00, 1'b0, 8'd1},  // R6 repeat off
        {2'd1, 8'h99, 1'b1, 8'd0},  // R5
        {2'd1, 8'hAB, 1'b0, 8'd0}   // R5
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              host_we;
    logic              host_sel;
    logic [CNT_W-1:0]  host_wdata;
    logic              in_valid;
    logic [DATA_W-1:0] in_data;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_eop;
    logic [CNT_W-1:0]  cnt_rd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_len_tagger #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
        .cnt_rd(cnt_rd)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // inputs applied just after a falling edge; combinational outputs checked
    // 1 time unit later, count checked at the next falling edge
    task automatic drive(input logic we, input logic sel, input logic [7:0] wd,
                         input logic v, input logic [7:0] d,
                         input logic exp_eop, input logic [7:0] exp_cnt, input string req);
        host_we = we; host_sel = sel; host_wdata = wd;
        in_valid = v; in_data = d;
        #1;
        check("R8", "out_valid", int'(out_valid), int'(v));
        if (v) check("R8", "out_data", int'(out_data), int'(d));
        check(req, "out_eop", int'(out_eop), int'(exp_eop));
        @(negedge clk);
        check(req, "cnt_rd", int'(cnt_rd), int'(exp_cnt));
        host_we = 1'b0; in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; host_we = 1'b0; host_sel = 1'b0; host_wdata = '0;
        in_valid = 1'b0; in_data = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1", "cnt_rd after reset", int'(cnt_rd), 0);
        drive(1'b0, 1'b0, 8'h00, 1'b1, 8'h5A, 1'b0, 8'd0, "R1");

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] dv;
            op = VEC[i][18:17];
            dv = VEC[i][16:9];
            case (op)
                2'd1:    drive(1'b0, 1'b0, 8'h00, 1'b1, dv, VEC[i][8], VEC[i][7:0], "R4/R6 table");
                2'd2:    drive(1'b1, 1'b0, dv, 1'b0, 8'h00, VEC[i][8], VEC[i][7:0], "R2 table");
                2'd3:    drive(1'b1, 1'b1, dv, 1'b0, 8'h00, VEC[i][8], VEC[i][7:0], "R6 table");
                default: drive(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, VEC[i][8], VEC[i][7:0], "R3 table");
            endcase
        end

        // R9 coincident length write and FIFO write
        drive(1'b1, 1'b0, 8'd5, 1'b0, 8'h00, 1'b0, 8'd5, "R2");
        drive(1'b1, 1'b0, 8'd9, 1'b1, 8'hC1, 1'b0, 8'd9, "R9");
        drive(1'b1, 1'b0, 8'd1, 1'b0, 8'h00, 1'b0, 8'd1, "R2");
        drive(1'b1, 1'b0, 8'd4, 1'b1, 8'hC2, 1'b1, 8'd4, "R9");

        // R10 reset clears repeat mode
        drive(1'b1, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 8'd4, "R6");
        do_reset();
        check("R10", "cnt_rd after reset", int'(cnt_rd), 0);
        drive(1'b1, 1'b0, 8'd1, 1'b0, 8'h00, 1'b0, 8'd1, "R10");
        drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hE7, 1'b1, 8'd0, "R10");
        drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hE8, 1'b0, 8'd0, "R10");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule